// File: doc/BRIEF.md
# Ethernet receive error statistics counters

This block sits behind an Ethernet receive MAC and keeps two 16-bit error statistics. The MAC hands over one summary strobe per received frame. The summary carries the total frame byte count, a flag for a trailing partial byte, an FCS-good flag, a VLAN-tag flag, the type/length field and the number of data bytes it actually measured. From each summary the block decides whether the frame is an alignment error, a length error, both, or neither. It then bumps the matching counters.

Software reaches both counters through a small register port. Address 0 selects the alignment counter and address 1 selects the length counter. Each counter is readable and writable. Read data is registered. The counter sits in the low 16 bits of a 32-bit word, and the high bits read as zero.

Top module: `rx_err_stats`

## Requirements
- R1: When a strobe (`frm_vld`=1) has `frm_fcs_ok`=0 and `frm_partial`=1, and `frm_bytes` lies between 64 and 1518 inclusive with `frm_vlan`=0, the alignment counter rises by one.
- R2: With `frm_vlan`=1 the upper alignment bound is 1522, so bad-FCS partial-byte frames of 1519 to 1522 bytes count only when tagged.
- R3: The alignment counter is unchanged by a strobe with good FCS, with no partial byte, below 64 bytes, or above the upper bound for its tag state.
- R4: When `frm_typelen` is at most 1500, the length counter rises by one if `frm_data_bytes` differs from the expected payload size. The expected size is the larger of `frm_typelen` and 46, because short payloads are padded to 46.
- R5: A `frm_typelen` above 1500 is an Ethertype and never changes the length counter.
- R6: `reg_addr`=0 selects the alignment counter and `reg_addr`=1 selects the length counter. `reg_rdata` is loaded on the clock edge after the address is presented. Bits 31:16 of `reg_rdata` are always zero.
- R7: Synchronous `rst` clears both counters and `reg_rdata` to zero.
- R8: `reg_wr`=1 loads `reg_wdata` into the addressed counter. This write wins over an increment of that counter in the same cycle.
- R9: A counter at 0xFFFF that increments becomes 0x0000.
- R10: One strobe raises each counter by at most one, and one frame may raise both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | Frame summary strobe, one cycle per frame |
| frm_bytes | input | 16 | Total frame size in bytes |
| frm_partial | input | 1 | Frame ended with a partial byte |
| frm_fcs_ok | input | 1 | FCS check passed |
| frm_vlan | input | 1 | Frame carried a VLAN tag |
| frm_typelen | input | 16 | Type/length field value |
| frm_data_bytes | input | 16 | Measured data byte count |
| reg_addr | input | 1 | Counter select (0 alignment, 1 length) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Value to load into the selected counter |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: 16-bit counters, a 64/1518/1522 size window and 46/1500 payload limits. These settings let a sweep of frame sizes from 60 to 1530 cross every window edge in both tag states and under every FCS and partial-byte combination. A second sweep covers every type/length value up to 1510, each with data counts one below, at, and one above the padded expectation. Preloading a counter through the write port puts wrap-around and write-versus-increment collisions within a few cycles of reach.

// File: rtl/rx_err_stats_pkg.sv
package rx_err_stats_pkg;
  localparam int FRM_W = 16;

  typedef struct packed {
    logic [FRM_W-1:0] bytes;
    logic             partial;
    logic             fcs_ok;
    logic             vlan;
    logic [FRM_W-1:0] typelen;
    logic [FRM_W-1:0] data_bytes;
  } frm_sum_t;

  localparam int N_CNT = 2;
  localparam int IDX_ALN = 0;
  localparam int IDX_LEN = 1;
endpackage

// File: rtl/rx_err_qualify.sv
module rx_err_qualify
  import rx_err_stats_pkg::*;
#(
  parameter int MIN_FRM   = 64,
  parameter int MAX_UNTAG = 1518,
  parameter int MAX_TAG   = 1522,
  parameter int MIN_DATA  = 46,
  parameter int MAX_LEN   = 1500
) (
  input  frm_sum_t sum,
  output logic     aln_hit,
  output logic     len_hit
);
  localparam logic [FRM_W-1:0] LO_FRM  = FRM_W'(MIN_FRM);
  localparam logic [FRM_W-1:0] HI_UNT  = FRM_W'(MAX_UNTAG);
  localparam logic [FRM_W-1:0] HI_TAG  = FRM_W'(MAX_TAG);
  localparam logic [FRM_W-1:0] PAD_MIN = FRM_W'(MIN_DATA);
  localparam logic [FRM_W-1:0] LEN_MAX = FRM_W'(MAX_LEN);

  logic [FRM_W-1:0] hi_bound;
  logic             in_window;
  logic             is_length;
  logic [FRM_W-1:0] expect_data;

  always_comb begin
    hi_bound    = sum.vlan ? HI_TAG : HI_UNT;
    in_window   = (sum.bytes >= LO_FRM) && (sum.bytes <= hi_bound);
    aln_hit     = !sum.fcs_ok && sum.partial && in_window;
    is_length   = (sum.typelen <= LEN_MAX);
    expect_data = (sum.typelen < PAD_MIN) ? PAD_MIN : sum.typelen;
    len_hit     = is_length && (sum.data_bytes != expect_data);
  end
endmodule

// File: rtl/rx_err_cnt.sv
module rx_err_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (wr_en) cnt <= wdata;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  AST_WR_PRIO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> (cnt == $past(wdata))); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> ((cnt == $past(cnt)) || (cnt == W'($past(cnt) + 1'b1)))); // R10
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(inc) && ($past(cnt) == {W{1'b1}})) |-> (cnt == '0)); // R9
endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
  import rx_err_stats_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int REG_W     = 32,
  parameter int MIN_FRM   = 64,
  parameter int MAX_UNTAG = 1518,
  parameter int MAX_TAG   = 1522,
  parameter int MIN_DATA  = 46,
  parameter int MAX_LEN   = 1500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_vld,
  input  logic [15:0]       frm_bytes,
  input  logic              frm_partial,
  input  logic              frm_fcs_ok,
  input  logic              frm_vlan,
  input  logic [15:0]       frm_typelen,
  input  logic [15:0]       frm_data_bytes,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  frm_sum_t   sum;
  logic       aln_hit, len_hit;
  logic [N_CNT-1:0] hit, inc, wr;
  logic [CNT_W-1:0] cnt [N_CNT];

  assign sum = '{bytes: frm_bytes, partial: frm_partial, fcs_ok: frm_fcs_ok,
                 vlan: frm_vlan, typelen: frm_typelen, data_bytes: frm_data_bytes};

  rx_err_qualify #(
    .MIN_FRM(MIN_FRM), .MAX_UNTAG(MAX_UNTAG), .MAX_TAG(MAX_TAG),
    .MIN_DATA(MIN_DATA), .MAX_LEN(MAX_LEN)
  ) u_qual (
    .sum(sum), .aln_hit(aln_hit), .len_hit(len_hit)
  );

  assign hit[IDX_ALN] = aln_hit;
  assign hit[IDX_LEN] = len_hit;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    assign inc[g] = frm_vld && hit[g];
    assign wr[g]  = reg_wr && (reg_addr == 1'(g));
    rx_err_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(inc[g]), .wr_en(wr[g]),
      .wdata(reg_wdata), .cnt(cnt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= REG_W'(cnt[reg_addr]);
  end

  AST_FCS_OK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && frm_fcs_ok && !(reg_wr && reg_addr == 1'b0)) |=> $stable(cnt[IDX_ALN])); // R3
  AST_ETYPE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && (frm_typelen > 16'(MAX_LEN)) && !(reg_wr && reg_addr == 1'b1)) |=> $stable(cnt[IDX_LEN])); // R5
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:CNT_W] == '0); // R6
  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (cnt[IDX_ALN] == '0 && cnt[IDX_LEN] == '0 && reg_rdata == '0)); // R7
endmodule

// File: tb/rx_err_stats_test.sv
module rx_err_stats_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        frm_vld = 0;
  logic [15:0] frm_bytes = 0;
  logic        frm_partial = 0;
  logic        frm_fcs_ok = 1;
  logic        frm_vlan = 0;
  logic [15:0] frm_typelen = 16'h0800;
  logic [15:0] frm_data_bytes = 0;
  logic        reg_addr = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] m_aln = 0;
  logic [15:0] m_len = 0;

  always #5 clk = ~clk;

  rx_err_stats uut (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_bytes(frm_bytes),
    .frm_partial(frm_partial), .frm_fcs_ok(frm_fcs_ok), .frm_vlan(frm_vlan),
    .frm_typelen(frm_typelen), .frm_data_bytes(frm_data_bytes),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; frm_vld = 0; reg_wr = 0;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic strobe(input int sz, input bit part, input bit fok, input bit vl,
                        input int tl, input int db);
    bit qa, ql;
    int hb, ex;
    @(negedge clk);
    frm_vld = 1; frm_bytes = 16'(sz); frm_partial = part; frm_fcs_ok = fok;
    frm_vlan = vl; frm_typelen = 16'(tl); frm_data_bytes = 16'(db);
    hb = vl ? 1522 : 1518;
    qa = !fok && part && sz >= 64 && sz <= hb;
    ex = (tl < 46) ? 46 : tl;
    ql = (tl <= 1500) && (db != ex);
    if (!(reg_wr && reg_addr == 0) && qa) m_aln = m_aln + 1'b1;
    if (!(reg_wr && reg_addr == 1) && ql) m_len = m_len + 1'b1;
    @(negedge clk); frm_vld = 0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a == 0) m_aln = d; else m_len = d;
    @(negedge clk); reg_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    rd(0, v); check("R7 alignment reset", v, 0);
    rd(1, v); check("R7 length reset", v, 0);

    // R1 R2 R3: sweep sizes across both windows, all FCS/partial combos
    for (int sz = 60; sz <= 1530; sz++) begin
      for (int vl = 0; vl < 2; vl++) begin
        for (int k = 0; k < 4; k++)
          strobe(sz, k[0], k[1], vl[0], 16'h0800, 0);
        rd(0, v);
        check((sz > 1518 && sz <= 1522) ? "R2 tagged window" :
              (sz < 64 || sz > 1522) ? "R3 outside window" : "R1 alignment count",
              v, {16'h0, m_aln});
      end
    end
    rd(1, v); check("R5 ethertype ignored during size sweep", v, {16'h0, m_len});

    // R4 R5: sweep length field with good FCS
    for (int tl = 0; tl <= 1510; tl++) begin
      int ex;
      ex = (tl < 46) ? 46 : tl;
      strobe(100, 0, 1, 0, tl, ex - 1);
      strobe(100, 0, 1, 0, tl, ex);
      strobe(100, 0, 1, 0, tl, ex + 1);
      rd(1, v);
      check(tl > 1500 ? "R5 ethertype ignored" : "R4 length mismatch", v, {16'h0, m_len});
    end
    strobe(100, 0, 1, 0, 16'h8100, 3);
    strobe(100, 0, 1, 0, 16'hFFFF, 0);
    rd(1, v); check("R5 large ethertype", v, {16'h0, m_len});
    rd(0, v); check("R3 good FCS leaves alignment", v, {16'h0, m_aln});

    // R10 both counters from one frame
    wr(0, 16'h0010); wr(1, 16'h0020);
    strobe(100, 1, 0, 0, 50, 60);
    rd(0, v); check("R10 alignment both", v, 32'h11);
    rd(1, v); check("R10 length both", v, 32'h21);

    // R9 wrap
    wr(0, 16'hFFFE);
    strobe(200, 1, 0, 1, 16'h0800, 0);
    rd(0, v); check("R9 reach max", v, 32'hFFFF);
    strobe(200, 1, 0, 1, 16'h0800, 0);
    rd(0, v); check("R9 wrap to zero", v, 32'h0);

    // R8 write wins over same-cycle increment
    @(negedge clk);
    reg_wr = 1; reg_addr = 1; reg_wdata = 16'h1234;
    frm_vld = 1; frm_bytes = 100; frm_partial = 1; frm_fcs_ok = 0; frm_vlan = 0;
    frm_typelen = 200; frm_data_bytes = 10;
    @(negedge clk); reg_wr = 0; frm_vld = 0;
    rd(1, v); check("R8 write priority", v, 32'h1234);
    rd(0, v); check("R10 other counter still counts", v, 32'h1);

    // R6 upper bits zero, address map
    wr(0, 16'hFFFF); wr(1, 16'h5A5A);
    rd(0, v); check("R6 upper zero alignment", v, 32'h0000FFFF);
    rd(1, v); check("R6 length at address 1", v, 32'h00005A5A);

    // R7 reset again
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R7 rdata after reset", reg_rdata, 0);
    rd(0, v); check("R7 alignment cleared", v, 0);
    rd(1, v); check("R7 length cleared", v, 0);

    done = 1;
    report();
    $finish;
  end
endmodule